// File: doc/BRIEF.md
# MSI Snooping Line Controller

This block keeps coherence for a small direct-mapped, write-back cache that sits on a shared snooping bus. Each line holds a tag, a data word and one of three states: Invalid, Shared or Modified. Two sources change a line's state: requests from the local processor, and transactions issued by other caches that this block observes on the bus.

A processor request is served in the same cycle when the line already gives the needed permission. If it does not, the block raises a single bus request. That request is a write-back of a dirty victim, a plain read, a read-for-ownership, or an upgrade of a Shared copy. The processor holds its request until it receives an acknowledge. Each bus transaction ends when the bus returns a done pulse, and the request is then evaluated again.

Snooped transactions from other caches are handled combinationally in the cycle they appear. When one hits a Modified line, the block flushes the dirty word. A snoop always wins over a local request in the same cycle, so local bus traffic never interleaves with a remote transaction.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first processor read of any address issues a bus request and no acknowledge.
- R2: A processor read whose tag matches a Shared or Modified line is acknowledged in the same cycle with the line's data on `cpu_rdata_o` and no bus request.
- R3: A processor write whose tag matches a Modified line is acknowledged in the same cycle without a bus request, and later reads return the written data.
- R4: A read miss issues bus command 0 (read) at the requested address. Once done, the line is Shared with the word from `bus_rdata_i`.
- R5: A write to a Shared line with a matching tag issues command 2 (upgrade). A write miss issues command 1 (read-exclusive). Either way the line becomes Modified, and the write is then acknowledged as a hit.
- R6: A snooped read (command 0) that hits a Modified line asserts `snp_flush_o` in that cycle with the line data on `snp_data_o`, and leaves the line Shared.
- R7: A snooped read-exclusive (1) or upgrade (2) that hits a line leaves it Invalid. It flushes only if the line was Modified.
- R8: A miss whose index holds a Modified line with another tag first issues a write-back (command 3) with the victim's address and data. The fill follows afterwards. A Shared victim is replaced without a write-back.
- R9: While `snp_valid_i` is high, `bus_req_o` and `cpu_ack_o` stay low.
- R10: A snoop that misses (Invalid line or different tag) does not flush and leaves the line unchanged.
- R11: A pending upgrade whose Shared line is invalidated by a snoop is reissued as read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor word address; low IDX_W bits select the line |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_ack_o | output | 1 | Request completed this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with the acknowledge of a read |
| bus_req_o | output | 1 | Local bus transaction requested |
| bus_cmd_o | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_done_i | input | 1 | Transaction completes at this clock edge |
| bus_rdata_i | input | DATA_W | Fill data for read and read-exclusive |
| snp_valid_i | input | 1 | Remote transaction visible this cycle |
| snp_cmd_i | input | 2 | Remote command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Remote transaction address |
| snp_flush_o | output | 1 | Dirty data supplied for the snooped line |
| snp_data_o | output | DATA_W | Flushed data |

## Verification
The state of each line is never shown directly at the ports. A wrong state appears at the very next access to that index. A line wrongly kept Modified produces an unexpected flush, or a stray write-back command, on the next snoop or miss. A line wrongly left valid turns a required bus request into an immediate acknowledge with stale read data. The checks are therefore built around sequences of reads, writes and snoops, each followed by another access to the same index. Every wrong state update is then caught within one or two transactions.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_UPG = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  line_st_e          wr_st_i,
  input  logic              wr_tag_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_dat_en_i,
  input  logic [DATA_W-1:0] wr_dat_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_st_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_dat_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_st_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_dat_o
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      st_q[wr_idx_i] <= wr_st_i;
      if (wr_tag_en_i) tag_q[wr_idx_i] <= wr_tag_i;
      if (wr_dat_en_i) dat_q[wr_idx_i] <= wr_dat_i;
    end
  end

  assign a_st_o  = st_q[a_idx_i];
  assign a_tag_o = tag_q[a_idx_i];
  assign a_dat_o = dat_q[a_idx_i];
  assign b_st_o  = st_q[b_idx_i];
  assign b_tag_o = tag_q[b_idx_i];
  assign b_dat_o = dat_q[b_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             snp_valid_i,
  input  bus_cmd_e         snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  line_st_e         line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             flush_o,
  output logic             upd_o,
  output line_st_e         upd_st_o
);
  logic hit;

  assign hit = snp_valid_i && (line_st_i != LN_INV) && (line_tag_i == snp_tag_i);

  always_comb begin
    upd_o    = 1'b0;
    upd_st_o = line_st_i;
    flush_o  = 1'b0;
    if (hit) begin
      unique case (snp_cmd_i)
        CMD_RD: begin
          flush_o  = (line_st_i == LN_MOD);
          upd_o    = (line_st_i == LN_MOD);
          upd_st_o = LN_SHR;
        end
        CMD_RDX, CMD_UPG: begin
          flush_o  = (line_st_i == LN_MOD);
          upd_o    = 1'b1;
          upd_st_o = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_req_unit.sv
module msi_req_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              snp_valid_i,
  input  logic              bus_done_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_dat_i,
  output logic              ack_o,
  output logic              breq_o,
  output bus_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] baddr_o,
  output logic              upd_o,
  output line_st_e          upd_st_o,
  output logic              upd_tag_en_o,
  output logic              upd_dat_en_o,
  output logic [DATA_W-1:0] upd_dat_o
);
  logic [TAG_W-1:0] tag_c;
  logic [IDX_W-1:0] idx_c;
  logic tag_eq, hit, go, done;

  assign tag_c  = cpu_addr_i[ADDR_W-1:IDX_W];
  assign idx_c  = cpu_addr_i[IDX_W-1:0];
  assign tag_eq = (line_tag_i == tag_c);
  assign hit    = tag_eq && (cpu_we_i ? (line_st_i == LN_MOD) : (line_st_i != LN_INV));
  // remote transactions own the bus in their cycle
  assign go     = cpu_req_i && !snp_valid_i;
  assign ack_o  = go && hit;
  assign breq_o = go && !hit;
  assign done   = breq_o && bus_done_i;

  always_comb begin
    if (line_st_i == LN_MOD && !tag_eq)            cmd_o = CMD_WB;
    else if (cpu_we_i && tag_eq && line_st_i == LN_SHR) cmd_o = CMD_UPG;
    else if (cpu_we_i)                             cmd_o = CMD_RDX;
    else                                           cmd_o = CMD_RD;
  end

  assign baddr_o = (cmd_o == CMD_WB) ? {line_tag_i, idx_c} : cpu_addr_i;

  always_comb begin
    upd_o        = 1'b0;
    upd_st_o     = line_st_i;
    upd_tag_en_o = 1'b0;
    upd_dat_en_o = 1'b0;
    upd_dat_o    = bus_rdata_i;
    if (ack_o && cpu_we_i) begin
      upd_o        = 1'b1;
      upd_st_o     = LN_MOD;
      upd_dat_en_o = 1'b1;
      upd_dat_o    = cpu_wdata_i;
    end else if (done) begin
      upd_o = 1'b1;
      unique case (cmd_o)
        CMD_WB:  upd_st_o = LN_INV;
        CMD_RD: begin
          upd_st_o = LN_SHR; upd_tag_en_o = 1'b1; upd_dat_en_o = 1'b1;
        end
        CMD_RDX: begin
          upd_st_o = LN_MOD; upd_tag_en_o = 1'b1; upd_dat_en_o = 1'b1;
        end
        CMD_UPG: upd_st_o = LN_MOD;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_done_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_st_e          c_st, s_st, r_upd_st, s_upd_st, wr_st;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic [DATA_W-1:0] c_dat, s_dat, r_upd_dat;
  logic              r_upd, r_tag_en, r_dat_en, s_upd;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  bus_cmd_e          r_cmd;

  msi_req_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .snp_valid_i (snp_valid_i),
    .bus_done_i  (bus_done_i),
    .bus_rdata_i (bus_rdata_i),
    .line_st_i   (c_st),
    .line_tag_i  (c_tag),
    .line_dat_i  (c_dat),
    .ack_o       (cpu_ack_o),
    .breq_o      (bus_req_o),
    .cmd_o       (r_cmd),
    .baddr_o     (bus_addr_o),
    .upd_o       (r_upd),
    .upd_st_o    (r_upd_st),
    .upd_tag_en_o(r_tag_en),
    .upd_dat_en_o(r_dat_en),
    .upd_dat_o   (r_upd_dat)
  );

  msi_snoop_unit #(.TAG_W(TAG_W)) u_snp (
    .snp_valid_i(snp_valid_i),
    .snp_cmd_i  (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i  (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i  (s_st),
    .line_tag_i (s_tag),
    .flush_o    (snp_flush_o),
    .upd_o      (s_upd),
    .upd_st_o   (s_upd_st)
  );

  // local updates are masked during snoops, so the two never collide
  assign wr_en  = s_upd || r_upd;
  assign wr_idx = s_upd ? snp_addr_i[IDX_W-1:0] : cpu_addr_i[IDX_W-1:0];
  assign wr_st  = s_upd ? s_upd_st : r_upd_st;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_st_i    (wr_st),
    .wr_tag_en_i(!s_upd && r_tag_en),
    .wr_tag_i   (cpu_addr_i[ADDR_W-1:IDX_W]),
    .wr_dat_en_i(!s_upd && r_dat_en),
    .wr_dat_i   (r_upd_dat),
    .a_idx_i    (cpu_addr_i[IDX_W-1:0]),
    .a_st_o     (c_st),
    .a_tag_o    (c_tag),
    .a_dat_o    (c_dat),
    .b_idx_i    (snp_addr_i[IDX_W-1:0]),
    .b_st_o     (s_st),
    .b_tag_o    (s_tag),
    .b_dat_o    (s_dat)
  );

  assign bus_cmd_o   = r_cmd;
  assign bus_wdata_o = c_dat;
  assign cpu_rdata_o = c_dat;
  assign snp_data_o  = s_dat;

  p_snoop_blocks_cpu_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> (!bus_req_o && !cpu_ack_o));

  p_ack_or_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !snp_valid_i) |-> (cpu_ack_o != bus_req_o));

  p_flush_needs_snoop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> (snp_valid_i && snp_cmd_i != CMD_WB));

  p_single_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |=> !(snp_flush_o && $stable(snp_addr_i)));

  p_wb_then_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_done_i && bus_cmd_o == CMD_WB)
      |=> (!$stable(cpu_addr_i) || !(bus_req_o && bus_cmd_o == CMD_WB)));

  p_read_fill_hits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_done_i && bus_cmd_o == CMD_RD)
      |=> (!(cpu_req_i && !cpu_we_i && $stable(cpu_addr_i) && !snp_valid_i) || cpu_ack_o));
endmodule

// File: tb/tb_msi_line_ctrl.sv
module tb_msi_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 8;
  localparam int LINES  = 1 << IDX_W;
  localparam int NADDR  = 1 << ADDR_W;
  localparam int S_I = 0, S_S = 1, S_M = 2;
  localparam int C_RD = 0, C_RDX = 1, C_UPG = 2, C_WB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ack_o;
  logic [DATA_W-1:0] cpu_rdata_o;
  logic bus_req_o;
  logic [1:0] bus_cmd_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;
  logic bus_done = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_flush_o;
  logic [DATA_W-1:0] snp_data_o;

  int n_tests = 0, n_fail = 0;
  int m_st [LINES];
  int m_tag[LINES];
  int m_dat[LINES];
  int mem  [NADDR];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_done_i(bus_done), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_flush_o(snp_flush_o), .snp_data_o(snp_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cpu_step(input bit grant, output bit fin);
    int idx, tg, st, ecmd, eaddr;
    bit teq, hit;
    string lbl;
    #1;
    idx = int'(cpu_addr) % LINES;
    tg  = int'(cpu_addr) / LINES;
    st  = m_st[idx];
    teq = (m_tag[idx] == tg);
    hit = cpu_we ? (teq && st == S_M) : (teq && st != S_I);
    if (hit) begin
      lbl = cpu_we ? "R3" : "R2";
      chk(lbl, int'(cpu_ack_o), 1);
      chk(lbl, int'(bus_req_o), 0);
      if (!cpu_we) chk("R2", int'(cpu_rdata_o), m_dat[idx]);
      @(posedge clk);
      if (cpu_we) m_dat[idx] = int'(cpu_wdata);
      @(negedge clk);
      fin = 1'b1;
    end else begin
      if (st == S_M && !teq) begin
        ecmd = C_WB; eaddr = m_tag[idx] * LINES + idx;
      end else begin
        eaddr = int'(cpu_addr);
        if (cpu_we) ecmd = (teq && st == S_S) ? C_UPG : C_RDX;
        else        ecmd = C_RD;
      end
      if (ecmd == C_WB || (st != S_I && !teq)) lbl = "R8";
      else if (ecmd == C_RD)                   lbl = "R4";
      else                                     lbl = "R5";
      chk(lbl, int'(bus_req_o), 1);
      chk(lbl, int'(cpu_ack_o), 0);
      chk(lbl, int'(bus_cmd_o), ecmd);
      chk(lbl, int'(bus_addr_o), eaddr);
      if (ecmd == C_WB) chk("R8", int'(bus_wdata_o), m_dat[idx]);
      if (grant) begin
        bus_done  = 1'b1;
        bus_rdata = DATA_W'(mem[eaddr]);
        @(posedge clk);
        case (ecmd)
          C_WB:  begin mem[eaddr] = m_dat[idx]; m_st[idx] = S_I; end
          C_RD:  begin m_tag[idx] = tg; m_dat[idx] = mem[eaddr]; m_st[idx] = S_S; end
          C_RDX: begin m_tag[idx] = tg; m_dat[idx] = mem[eaddr]; m_st[idx] = S_M; end
          default: m_st[idx] = S_M;
        endcase
        @(negedge clk);
        bus_done = 1'b0;
      end else begin
        @(posedge clk);
        @(negedge clk);
      end
      fin = 1'b0;
    end
  endtask

  task automatic cpu_access(input bit we, input int addr, input int wd);
    bit fin;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = DATA_W'(wd);
    fin = 1'b0;
    for (int k = 0; k < 6 && !fin; k++) cpu_step(1'b1, fin);
    if (!fin) chk(we ? "R5" : "R4", 0, 1);
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input int cmd, input int addr);
    int idx, tg;
    bit hit, ef;
    string lbl;
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = ADDR_W'(addr);
    #1;
    idx = addr % LINES; tg = addr / LINES;
    hit = (m_st[idx] != S_I) && (m_tag[idx] == tg);
    ef  = hit && m_st[idx] == S_M;
    lbl = !hit ? "R10" : (cmd == C_RD ? "R6" : "R7");
    chk(lbl, int'(snp_flush_o), int'(ef));
    if (ef) chk(lbl, int'(snp_data_o), m_dat[idx]);
    if (cpu_req) begin
      chk("R9", int'(bus_req_o), 0);
      chk("R9", int'(cpu_ack_o), 0);
    end
    @(posedge clk);
    if (ef) mem[addr] = m_dat[idx];
    if (hit) m_st[idx] = (cmd == C_RD) ? S_S : S_I;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit fin;
    for (int i = 0; i < LINES; i++) begin m_st[i] = S_I; m_tag[i] = 0; m_dat[i] = 0; end
    for (int a = 0; a < NADDR; a++) mem[a] = (a * 5 + 17) % 256;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: idle after reset, then address 0 (tag 0) must still miss
    chk("R1", int'(bus_req_o), 0);
    chk("R1", int'(cpu_ack_o), 0);
    chk("R1", int'(snp_flush_o), 0);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = '0;
    #1;
    chk("R1", int'(bus_req_o), 1);
    chk("R1", int'(cpu_ack_o), 0);
    @(negedge clk);
    cpu_req = 1'b0;

    // read sweep: fills and silent Shared replacement
    for (int a = 0; a < NADDR; a++) cpu_access(1'b0, a, 0);
    for (int a = NADDR - LINES; a < NADDR; a++) cpu_access(1'b0, a, 0);
    // write sweep: upgrades, read-exclusive, write-backs
    for (int a = 0; a < NADDR; a++) cpu_access(1'b1, a, a ^ 8'h5a);
    for (int a = NADDR - LINES; a < NADDR; a++) begin
      cpu_access(1'b1, a, a + 100);
      cpu_access(1'b0, a, 0);
    end
    // snoops on Modified lines, then Shared, then misses
    snoop(C_RD,  NADDR - 4);
    snoop(C_RD,  NADDR - 4);
    snoop(C_RDX, NADDR - 3);
    snoop(C_UPG, NADDR - 2);
    snoop(C_RDX, NADDR - 4);
    snoop(C_RD,  1);
    cpu_access(1'b0, NADDR - 1, 0);
    cpu_access(1'b0, NADDR - 3, 0);

    // R11: upgrade lost to a remote read-exclusive
    cpu_access(1'b0, 6, 0);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ADDR_W'(6); cpu_wdata = 8'hc3;
    cpu_step(1'b0, fin);
    snoop(C_RDX, 6);
    #1;
    chk("R11", int'(bus_cmd_o), C_RDX);
    chk("R11", int'(bus_req_o), 1);
    fin = 1'b0;
    for (int k = 0; k < 6 && !fin; k++) cpu_step(1'b1, fin);
    cpu_req = 1'b0;
    cpu_access(1'b0, 6, 0);

    // mixed near-exhaustive pattern
    for (int i = 0; i < 300; i++) begin
      int a;
      a = (i * 37 + 11) % NADDR;
      case (i % 3)
        0: cpu_access(1'b0, a, 0);
        1: cpu_access(1'b1, a, (i * 3) % 256);
        default: snoop((i / 3) % 3, (a + (i % 2) * LINES) % NADDR);
      endcase
    end

    summary();
    $finish;
  end
endmodule